// File: doc/BRIEF.md
# Multi-plane NAND program and erase sequencer

This block is the controller-side engine that runs one multi-plane operation on an 8-bit NAND flash bus. The host presents up to four request slots. Each slot has an enable bit, a block address and a page offset. The host also picks program or erase and pulses `start`. The sequencer checks the request. It then emits the command, address and data cycles for every enabled slot, in slot order, with one write strobe per bus cycle. It waits for the flash to leave busy, reads the extended status byte once, and reports one pass/fail bit per plane.

The plane that a slot targets is given by the two low bits of its block address. The slots may therefore name planes in any order. A request is refused before any bus cycle is issued in three cases: it selects no slot, two of its slots hit the same plane, or (for a program) the selected pages differ in their in-block page offset. A program page is streamed from the host one byte per cycle through a request/index interface.

A busy flag that never clears ends the operation with a timeout flag. In that case every selected plane is reported as failed.

Top module: `nand_mp_seq`

## Requirements
- R1: A program sends, for each enabled slot in ascending slot order, command 80h, then its address cycles, then its data cycles, then a confirm command. The confirm is 11h for every slot except the last enabled one, which gets 10h. After 10h no further program command is issued.
- R2: A program slot takes four address cycles: a column byte 00h, then the row value {block, page} with the page in row bits 4:0, sent least significant byte first over three cycles. An erase slot takes three address cycles carrying {block, 5'b0}, least significant byte first.
- R3: Each program slot takes exactly PAGE_BYTES data cycles. During them `data_req` is high, `data_plane` equals the slot's block bits 1:0, `data_idx` counts up from 0, and `data_in` is driven onto the bus in the same cycle.
- R4: An erase sends command 60h and three address cycles for each enabled slot, in slot order, followed by a single D0h.
- R5: A program whose enabled slots do not all carry the same 5-bit page offset is refused. For a refusal: no bus cycle, `done` pulses with `err_req`=1, and `result`=0000. The page offsets are ignored for an erase.
- R6: A request with no enabled slot, or with two enabled slots whose block bits 1:0 are equal, is refused in the same way.
- R7: After the final confirm (10h or D0h), the block issues no bus cycle for at least one clock. It then waits for `nf_rdy` high before issuing command 71h.
- R8: After 71h, the block performs exactly one read cycle (`nf_re` high). Status bit p+1 set means plane p failed. `result[p]` is 1 (pass) unless plane p was selected and its fail bit is set, so unselected planes read as pass.
- R9: If `nf_rdy` stays low for TMO_CYC cycles, the operation ends with `err_tmo`=1 and `result` equal to the inverse of the selected plane mask. No 71h is issued.
- R10: `busy` is high from the cycle after an accepted `start` until completion. `done` is a one-cycle pulse. `nf_cle` and `nf_ale` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| start | input | 1 | begin an operation (sampled while idle) |
| op_erase | input | 1 | 1 = multi-plane erase, 0 = multi-plane program |
| slot_en | input | 4 | enable per request slot |
| slot_blk | input | 4*BLK_W | block address per slot, slot 0 in the low bits |
| slot_page | input | 20 | 5-bit page offset per slot, slot 0 in the low bits |
| data_in | input | 8 | page byte for the current data cycle |
| nf_io_in | input | 8 | flash bus read data |
| nf_rdy | input | 1 | flash ready (1) / busy (0) |
| busy | output | 1 | operation in progress |
| done | output | 1 | one-cycle completion pulse |
| err_req | output | 1 | last request was refused |
| err_tmo | output | 1 | last operation timed out on busy |
| result | output | 4 | per-plane pass (1) / fail (0) |
| data_req | output | 1 | data cycle in progress, `data_in` consumed |
| data_plane | output | 2 | plane of the current data cycle |
| data_idx | output | $clog2(PAGE_BYTES) | byte index of the current data cycle |
| nf_io_out | output | 8 | flash bus write data |
| nf_cle | output | 1 | command latch enable |
| nf_ale | output | 1 | address latch enable |
| nf_we | output | 1 | write strobe, one per bus write cycle |
| nf_re | output | 1 | read strobe |

## Verification
A full four-plane program in slot order with all planes passing exercises the 11h/10h chaining, the full address layout and the data stream length. A two-slot program whose slots name planes 3 and 1 through slots 0 and 2 tells apart slot order from plane order, and a single failing plane there shows the status bits are mapped per plane. A three-plane erase with mismatched page fields, with fail bits set on a selected and an unselected plane, separates erase framing from program framing and shows unselected planes read as pass. Refused requests (page mismatch, shared plane, empty) and a flash stuck busy cover the paths that must issue no bus cycle or no status read.

// File: rtl/nand_mp_seq.sv
module nand_mp_seq #(
  parameter int BLK_W      = 12,
  parameter int PAGE_BYTES = 528,
  parameter int TMO_CYC    = 4096
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic                    op_erase,
  input  logic [3:0]              slot_en,
  input  logic [4*BLK_W-1:0]      slot_blk,
  input  logic [19:0]             slot_page,
  input  logic [7:0]              data_in,
  input  logic [7:0]              nf_io_in,
  input  logic                    nf_rdy,
  output logic                    busy,
  output logic                    done,
  output logic                    err_req,
  output logic                    err_tmo,
  output logic [3:0]              result,
  output logic                    data_req,
  output logic [1:0]              data_plane,
  output logic [$clog2(PAGE_BYTES)-1:0] data_idx,
  output logic [7:0]              nf_io_out,
  output logic                    nf_cle,
  output logic                    nf_ale,
  output logic                    nf_we,
  output logic                    nf_re
);
  localparam int IW   = $clog2(PAGE_BYTES);
  localparam int CMAX = (PAGE_BYTES > TMO_CYC) ? PAGE_BYTES : TMO_CYC;
  localparam int CW   = $clog2(CMAX + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_CMD, S_ADDR, S_DATA, S_CONF, S_GAP, S_WAIT, S_STCMD, S_STRD, S_DONE
  } st_t;

  st_t                   st;
  logic                  op_q;
  logic [3:0]            en_q, pmask;
  logic [3:0][BLK_W-1:0] blk_q;
  logic [3:0][4:0]       page_q;
  logic [1:0]            cur;
  logic [CW-1:0]         cnt;
  logic [3:0]            res_q;
  logic                  ereq_q, etmo_q;

  logic [3:0][BLK_W-1:0] in_blk;
  logic [3:0][4:0]       in_page;
  logic                  bad, nx_ok;
  logic [1:0]            first_i, nx_i;
  logic [3:0]            in_mask;

  assign in_blk  = slot_blk;
  assign in_page = slot_page;

  always_comb begin
    bad     = (slot_en == 4'b0000);
    in_mask = 4'b0000;
    first_i = 2'd0;
    for (int i = 3; i >= 0; i--)
      if (slot_en[i]) begin
        first_i = 2'(i);
        in_mask[in_blk[i][1:0]] = 1'b1;
      end
    for (int i = 0; i < 4; i++)
      for (int j = i + 1; j < 4; j++)
        if (slot_en[i] && slot_en[j]) begin
          if (in_blk[i][1:0] == in_blk[j][1:0]) bad = 1'b1;
          if (!op_erase && in_page[i] != in_page[j]) bad = 1'b1;
        end
  end

  always_comb begin
    nx_ok = 1'b0;
    nx_i  = cur;
    for (int k = 3; k >= 0; k--)
      if (en_q[k] && k > int'(cur)) begin
        nx_ok = 1'b1;
        nx_i  = 2'(k);
      end
  end

  logic [23:0] row;
  logic [1:0]  rsel;
  logic [7:0]  addr_byte;
  assign row  = 24'({blk_q[cur], (op_q ? 5'd0 : page_q[cur])});
  assign rsel = op_q ? cnt[1:0] : cnt[1:0] - 2'd1;
  always_comb begin
    case (rsel)
      2'd0:    addr_byte = row[7:0];
      2'd1:    addr_byte = row[15:8];
      default: addr_byte = row[23:16];
    endcase
    if (!op_q && cnt == '0) addr_byte = 8'h00;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      op_q   <= 1'b0;
      en_q   <= '0;
      pmask  <= '0;
      blk_q  <= '0;
      page_q <= '0;
      cur    <= '0;
      cnt    <= '0;
      res_q  <= '0;
      ereq_q <= 1'b0;
      etmo_q <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          etmo_q <= 1'b0;
          if (bad) begin
            ereq_q <= 1'b1;
            res_q  <= 4'b0000;
            st     <= S_DONE;
          end else begin
            ereq_q <= 1'b0;
            op_q   <= op_erase;
            en_q   <= slot_en;
            pmask  <= in_mask;
            blk_q  <= in_blk;
            page_q <= in_page;
            cur    <= first_i;
            cnt    <= '0;
            st     <= S_CMD;
          end
        end
        S_CMD: begin
          cnt <= '0;
          st  <= S_ADDR;
        end
        S_ADDR: begin
          if (cnt == (op_q ? CW'(2) : CW'(3))) begin
            cnt <= '0;
            if (!op_q)      st <= S_DATA;
            else if (!nx_ok) st <= S_CONF;
            else begin
              cur <= nx_i;
              st  <= S_CMD;
            end
          end else cnt <= cnt + 1'b1;
        end
        S_DATA: begin
          if (cnt == CW'(PAGE_BYTES - 1)) begin
            cnt <= '0;
            st  <= S_CONF;
          end else cnt <= cnt + 1'b1;
        end
        S_CONF: begin
          cnt <= '0;
          if (!op_q && nx_ok) begin
            cur <= nx_i;
            st  <= S_CMD;
          end else st <= S_GAP;
        end
        S_GAP: st <= S_WAIT;
        S_WAIT: begin
          if (nf_rdy) st <= S_STCMD;
          else if (cnt == CW'(TMO_CYC - 1)) begin
            etmo_q <= 1'b1;
            res_q  <= ~pmask;
            st     <= S_DONE;
          end else cnt <= cnt + 1'b1;
        end
        S_STCMD: st <= S_STRD;
        S_STRD: begin
          res_q <= ~(pmask & nf_io_in[4:1]);
          st    <= S_DONE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  logic last_conf;
  assign last_conf = (st == S_CONF) && (op_q || !nx_ok);

  assign busy       = (st != S_IDLE) && (st != S_DONE);
  assign done       = (st == S_DONE);
  assign err_req    = ereq_q;
  assign err_tmo    = etmo_q;
  assign result     = res_q;
  assign data_req   = (st == S_DATA);
  assign data_plane = blk_q[cur][1:0];
  assign data_idx   = cnt[IW-1:0];
  assign nf_cle     = (st == S_CMD) || (st == S_CONF) || (st == S_STCMD);
  assign nf_ale     = (st == S_ADDR);
  assign nf_we      = nf_cle || nf_ale || data_req;
  assign nf_re      = (st == S_STRD);

  always_comb begin
    case (st)
      S_CMD:   nf_io_out = op_q ? 8'h60 : 8'h80;
      S_CONF:  nf_io_out = op_q ? 8'hD0 : (last_conf ? 8'h10 : 8'h11);
      S_STCMD: nf_io_out = 8'h71;
      S_ADDR:  nf_io_out = addr_byte;
      S_DATA:  nf_io_out = data_in;
      default: nf_io_out = 8'h00;
    endcase
  end

  // R10
  cle_ale_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(nf_cle && nf_ale));
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R5 R6
  reject_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err_req) |-> ($past(!nf_we) && !nf_we && !nf_re));
  // R7
  confirm_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nf_we && nf_cle && (nf_io_out == 8'h10 || nf_io_out == 8'hD0)) |=> (!nf_we && !nf_re));
  // R8
  read_after_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nf_re |-> $past(nf_we && nf_cle && nf_io_out == 8'h71));
  // R8
  unsel_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err_req) |-> ((result | pmask) == 4'hF));
endmodule

// File: tb/nand_mp_seq_tb.sv
module nand_mp_seq_tb;
  localparam int BLK_W = 12;
  localparam int PB    = 528;
  localparam int IW    = $clog2(PB);

  logic clk = 0, rst_n = 0, start = 0, op_erase = 0;
  logic [3:0] slot_en = 0;
  logic [4*BLK_W-1:0] slot_blk = 0;
  logic [19:0] slot_page = 0;
  logic [7:0] data_in, nf_io_in;
  logic nf_rdy;
  logic busy, done, err_req, err_tmo, data_req, nf_cle, nf_ale, nf_we, nf_re;
  logic [3:0] result;
  logic [1:0] data_plane;
  logic [IW-1:0] data_idx;
  logic [7:0] nf_io_out;

  always #5 clk = ~clk;

  nand_mp_seq #(.BLK_W(BLK_W), .PAGE_BYTES(PB)) u_dut (
    .clk, .rst_n, .start, .op_erase, .slot_en, .slot_blk, .slot_page, .data_in,
    .nf_io_in, .nf_rdy, .busy, .done, .err_req, .err_tmo, .result, .data_req,
    .data_plane, .data_idx, .nf_io_out, .nf_cle, .nf_ale, .nf_we, .nf_re);

  function automatic logic [7:0] dbyte(input logic [1:0] p, input int i);
    return 8'(i) ^ {p, 6'h2A};
  endfunction
  assign data_in = dbyte(data_plane, int'(data_idx));

  // responder
  logic [3:0] fail_bits = 0;
  logic stuck = 0;
  int hold = 20, bcnt;
  logic [7:0] cmd_log[64];
  logic [7:0] addr_log[64];
  int ncmd = 0, naddr = 0, ndata = 0, nread = 0, re_busy = 0, bad_idx = 0;
  longint dsum = 0;
  logic [1:0] exp_plane = 0;
  int exp_idx = 0;

  assign nf_io_in = nf_re ? {1'b0, nf_rdy, 1'b0, fail_bits, 1'b0} : 8'h00;

  always @(posedge clk) begin
    if (!rst_n) begin
      nf_rdy <= 1'b1;
      bcnt   <= 0;
    end else begin
      if (nf_we && nf_cle) begin
        cmd_log[ncmd % 64] <= nf_io_out;
        ncmd <= ncmd + 1;
      end
      if (nf_we && nf_ale) begin
        addr_log[naddr % 64] <= nf_io_out;
        naddr <= naddr + 1;
      end
      if (nf_we && !nf_cle && !nf_ale) begin
        ndata <= ndata + 1;
        dsum  <= dsum + longint'(nf_io_out);
        if (!data_req || data_plane != exp_plane || int'(data_idx) != exp_idx) bad_idx <= bad_idx + 1;
        exp_idx <= (exp_idx == PB - 1) ? 0 : exp_idx + 1;
      end
      if (nf_re) begin
        nread <= nread + 1;
        if (!nf_rdy) re_busy <= re_busy + 1;
      end
      if (nf_we && nf_cle && (nf_io_out == 8'h10 || nf_io_out == 8'hD0)) begin
        nf_rdy <= 1'b0;
        bcnt   <= hold;
      end else if (!nf_rdy && !stuck) begin
        if (bcnt == 0) nf_rdy <= 1'b1;
        else bcnt <= bcnt - 1;
      end else if (!stuck) nf_rdy <= 1'b1;
    end
  end

  int total = 0, bad_n = 0;
  task automatic chk(input logic ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad_n++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  int c0, a0, d0, r0, busy_seen;
  longint s0;

  task automatic run_op(input logic er, input logic [3:0] en,
                        input logic [3:0][BLK_W-1:0] b, input logic [3:0][4:0] pg);
    c0 = ncmd; a0 = naddr; d0 = ndata; r0 = nread; s0 = dsum; busy_seen = 0;
    @(negedge clk);
    op_erase = er; slot_en = en; slot_blk = b; slot_page = pg; start = 1;
    @(negedge clk);
    start = 0;
    for (int t = 0; t < 20000 && !done; t++) begin
      if (busy) busy_seen = 1;
      @(negedge clk);
    end
    chk(done, "R10 done reached", done, 1);
  endtask

  task automatic after_done;
    @(negedge clk);
    chk(!done && !busy, "R10 done is one pulse", {done, busy}, 0);
  endtask

  task automatic t_reset;
    chk(!busy && !done && !nf_we && !nf_re && !nf_cle && !nf_ale, "R10 reset state",
        {busy, done, nf_we, nf_re}, 0);
  endtask

  task automatic t_prog4;
    logic [3:0][BLK_W-1:0] b;
    logic [7:0] ec[9];
    longint es = 0;
    b[0] = 12'h104; b[1] = 12'h209; b[2] = 12'h00E; b[3] = 12'h3F3;
    fail_bits = 4'b0000; hold = 30;
    ec = '{8'h80, 8'h11, 8'h80, 8'h11, 8'h80, 8'h11, 8'h80, 8'h10, 8'h71};
    fork
      begin
        exp_plane = 2'd0;
        wait (ndata == d0 + PB);     exp_plane = 2'd1;
        wait (ndata == d0 + 2 * PB); exp_plane = 2'd2;
        wait (ndata == d0 + 3 * PB); exp_plane = 2'd3;
      end
      run_op(1'b0, 4'b1111, b, {4{5'd7}});
    join
    chk(busy_seen == 1, "R10 busy during program", busy_seen, 1);
    chk(ncmd - c0 == 9, "R1 program command count", ncmd - c0, 9);
    for (int k = 0; k < 9; k++)
      chk(cmd_log[(c0 + k) % 64] == ec[k], "R1 program command order", cmd_log[(c0 + k) % 64], ec[k]);
    chk(naddr - a0 == 16, "R2 program address count", naddr - a0, 16);
    chk(addr_log[(a0 + 8) % 64] == 8'h00 && addr_log[(a0 + 9) % 64] == 8'hC7 &&
        addr_log[(a0 + 10) % 64] == 8'h01 && addr_log[(a0 + 11) % 64] == 8'h00,
        "R2 program row bytes", addr_log[(a0 + 9) % 64], 8'hC7);
    chk(ndata - d0 == 4 * PB, "R3 data cycle count", ndata - d0, 4 * PB);
    for (int p = 0; p < 4; p++)
      for (int i = 0; i < PB; i++) es += longint'(dbyte(2'(p), i));
    chk(dsum - s0 == es, "R3 data bytes", dsum - s0, es);
    chk(bad_idx == 0, "R3 data plane and index", bad_idx, 0);
    chk(nread - r0 == 1 && re_busy == 0, "R7 R8 one read after ready", nread - r0, 1);
    chk(result == 4'hF && !err_req && !err_tmo, "R8 all planes pass", result, 4'hF);
    after_done();
  endtask

  task automatic t_prog2;
    logic [3:0][BLK_W-1:0] b;
    longint es = 0;
    b = '0; b[0] = 12'h007; b[2] = 12'h011;
    fail_bits = 4'b0010; hold = 5;
    fork
      begin
        exp_plane = 2'd3;
        wait (ndata == d0 + PB); exp_plane = 2'd1;
      end
      run_op(1'b0, 4'b0101, b, {5'd0, 5'd31, 5'd3, 5'd31});
    join
    chk(ncmd - c0 == 5 && cmd_log[c0 % 64] == 8'h80 && cmd_log[(c0 + 1) % 64] == 8'h11 &&
        cmd_log[(c0 + 2) % 64] == 8'h80 && cmd_log[(c0 + 3) % 64] == 8'h10 &&
        cmd_log[(c0 + 4) % 64] == 8'h71, "R1 two-slot chain", ncmd - c0, 5);
    chk(addr_log[(a0 + 1) % 64] == 8'hFF && addr_log[(a0 + 2) % 64] == 8'h00,
        "R2 row of slot 0 with page 31", addr_log[(a0 + 1) % 64], 8'hFF);
    for (int i = 0; i < PB; i++) es += longint'(dbyte(2'd3, i)) + longint'(dbyte(2'd1, i));
    chk(dsum - s0 == es && bad_idx == 0, "R3 data planes in slot order", dsum - s0, es);
    chk(result == 4'b1101, "R8 plane 1 fails", result, 4'b1101);
    after_done();
  endtask

  task automatic t_erase;
    logic [3:0][BLK_W-1:0] b;
    b = '0; b[1] = 12'h0A6; b[2] = 12'h100; b[3] = 12'h0F5;
    fail_bits = 4'b1001; hold = 12;
    run_op(1'b1, 4'b1110, b, {5'd4, 5'd9, 5'd1, 5'd0});
    chk(!err_req, "R5 page ignored for erase", err_req, 0);
    chk(ncmd - c0 == 5 && cmd_log[c0 % 64] == 8'h60 && cmd_log[(c0 + 1) % 64] == 8'h60 &&
        cmd_log[(c0 + 2) % 64] == 8'h60 && cmd_log[(c0 + 3) % 64] == 8'hD0 &&
        cmd_log[(c0 + 4) % 64] == 8'h71, "R4 erase command order", ncmd - c0, 5);
    chk(naddr - a0 == 9, "R4 erase address count", naddr - a0, 9);
    chk(addr_log[a0 % 64] == 8'hC0 && addr_log[(a0 + 1) % 64] == 8'h14 &&
        addr_log[(a0 + 2) % 64] == 8'h00, "R2 erase row bytes", addr_log[a0 % 64], 8'hC0);
    chk(ndata == d0, "R4 no data cycles in erase", ndata - d0, 0);
    chk(nread - r0 == 1 && re_busy == 0, "R7 erase status after ready", nread - r0, 1);
    chk(result == 4'b1110, "R8 unselected plane reads pass", result, 4'b1110);
    after_done();
  endtask

  task automatic t_rej(input logic [3:0] en, input logic [3:0][BLK_W-1:0] b,
                       input logic [3:0][4:0] pg, input string req);
    run_op(1'b0, en, b, pg);
    chk(err_req && result == 4'b0000 && !err_tmo, req, {err_req, result}, 5'h10);
    chk(ncmd == c0 && naddr == a0 && ndata == d0 && nread == r0 && busy_seen == 0,
        req, ncmd - c0 + naddr - a0, 0);
    after_done();
  endtask

  task automatic t_tmo;
    logic [3:0][BLK_W-1:0] b;
    b = '0; b[0] = 12'h02A;
    stuck = 1; fail_bits = 4'b0000;
    exp_plane = 2'd2;
    run_op(1'b0, 4'b0001, b, '0);
    chk(err_tmo && !err_req, "R9 timeout flag", err_tmo, 1);
    chk(result == 4'b1011, "R9 selected plane fails on timeout", result, 4'b1011);
    chk(ncmd - c0 == 2 && cmd_log[(c0 + 1) % 64] == 8'h10 && nread == r0,
        "R9 no status read on timeout", ncmd - c0, 2);
    after_done();
    stuck = 0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_prog4();
    t_prog2();
    t_erase();
    t_rej(4'b0011, {12'h0, 12'h0, 12'h005, 12'h002}, {5'd0, 5'd0, 5'd4, 5'd3}, "R5 page mismatch refused");
    t_rej(4'b1001, {12'h008, 12'h0, 12'h0, 12'h004}, '0, "R6 shared plane refused");
    t_rej(4'b0000, '0, '0, "R6 empty request refused");
    t_tmo();
    $display("test done: total=%0d bad=%0d", total, bad_n);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad_n++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad_n);
    $finish;
  end
endmodule